// File: doc/BRIEF.md
# Double-Buffered Output Handshake Port

This block is the output side of a parallel peripheral port. The host pushes bytes in with a single-cycle write strobe. Each byte passes through a two-stage path: a front buffer and the output latch that drives the peripheral data pins. The peripheral takes the byte on the output latch by raising its acknowledge line (H1). As soon as that byte has been accepted, a waiting byte in the front buffer moves into the output latch.

A second handshake pin (H2) is set by a 2-bit mode field. It can be:
- an edge-sensitive input that latches a status flag,
- a constant low output,
- a constant high output, or
- an interlocked "data valid" output.

In the interlocked mode, H2 rises two clocks after a byte lands in the output latch. It drops in the same cycle that the acknowledge rises. Acknowledges that arrive while H2 is low are ignored.

The acknowledge status output has two selectable meanings: "room for another byte" or "both stages empty". This lets an interrupt routine either top up the buffer or wait for it to drain.

Top module: `dbo_port`

## Requirements
- R1: After a synchronous active-low reset, both stages are empty, `port_data` is 0, `hs_out` is 0, `wr_reject` is 0 and `h2_status` is 0. `h1_status` reads 1 in both selections.
- R2: A write into an empty path appears on `port_data` after the next clock edge. A second write waits in the front buffer. While the latched byte is not accepted, `port_data` holds its value. After acceptance, the front byte appears on `port_data` after that same edge.
- R3: With `h1s_sel` = 0, `h1_status` is 1 whenever at least one stage is free, and 0 when both stages hold data.
- R4: With `h1s_sel` = 1, `h1_status` is 1 only when both stages are empty.
- R5: A write that arrives while both stages are full is dropped. `wr_reject` is then 1 for exactly the one cycle after that edge, and the stored bytes are unchanged.
- R6: In modes 00, 01 and 10, a byte is accepted only on a clock edge where `ack_in` has gone from 0 to 1 and the output latch holds data. A level held high accepts nothing further, and an edge with an empty latch has no effect.
- R7: In mode 11 with `enable` = 1, `hs_out` is 1 from the second clock edge after a byte is loaded into the output latch.
- R8: In mode 11, `hs_out` falls combinationally in the same cycle that `ack_in` rises. It returns to 1 two edges after the next byte is loaded.
- R9: In mode 11, an `ack_in` rise while `hs_out` is 0 leaves the data path unchanged.
- R10: In mode 11 with `enable` = 0, `hs_out` is held at 0 and acknowledges are ignored. When `enable` returns to 1 with a settled byte, `hs_out` is 1 again.
- R11: Mode 01 drives `hs_out` = 0 and mode 10 drives `hs_out` = 1, both with `hs_drive` = 1. In modes 01, 10 and 11, `h2_status` is 0.
- R12: In mode 00 (`hs_drive` = 0), a rise on `hs_in` sets `h2_status` after that edge. The flag is cleared by `h2s_clr`, and while `enable` is 0. A clear in the same cycle as a rise wins.
- R13: The `h2_mode` encoding is: 00 edge input, 01 output low, 10 output high, 11 interlocked handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | DW | Host write byte |
| wr_reject | output | 1 | One-cycle pulse: last write was dropped |
| ack_in | input | 1 | Peripheral acknowledge (H1), rising edge asserted |
| hs_in | input | 1 | H2 pin input value (mode 00) |
| hs_out | output | 1 | H2 pin output value |
| hs_drive | output | 1 | 1 when H2 is driven as an output |
| port_data | output | DW | Output latch contents to the peripheral |
| enable | input | 1 | Handshake pair enable |
| h2_mode | input | 2 | H2 behaviour select |
| h1s_sel | input | 1 | Acknowledge status meaning: 0 room, 1 drained |
| h2s_clr | input | 1 | Direct clear of the H2 status flag |
| h1_status | output | 1 | Acknowledge status |
| h2_status | output | 1 | H2 edge status |

## Verification
The bench targets the interlocked timing.
- It samples `hs_out` on each of the two cycles after a load. A design that counts from the write instead of the latch transfer, or that is off by one register, asserts H2 early or late.
- It raises `ack_in` and reads `hs_out` before the next clock edge. A design with a registered negation fails that check.
- It raises `ack_in` during the two-cycle settle window and while `enable` is low. A design that accepts these loses a byte, which shows as an early empty status.

The bench also covers the remaining corner cases:
- A write into a full path must not overwrite stored data.
- A held-high acknowledge must not drain a second byte.
- A clear that coincides with an H2 input edge must leave the flag cleared.

// File: rtl/dbo_pkg.sv
// Shared types for the double-buffered output port.
// Assumes nothing beyond a 2-bit H2 mode select field.
package dbo_pkg;
    typedef enum logic [1:0] {
        H2_EDGE_IN   = 2'b00,
        H2_DRIVE_LO  = 2'b01,
        H2_DRIVE_HI  = 2'b10,
        H2_INTERLOCK = 2'b11
    } h2_mode_e;
endpackage

// File: rtl/dbo_rise_det.sv
// Rising-edge detector for a vector of synchronous inputs.
// Assumes inputs are already synchronous to clk; rise is combinational
// so it is visible in the same cycle the input goes high.
module dbo_rise_det #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    // Remember last sampled value of each input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sig;
    end

    assign rise = sig & ~prev_q;
endmodule

// File: rtl/dbo_latch_pair.sv
// Two-stage output path: front buffer feeding the output latch.
// The front byte moves into the latch on the same edge the latched byte is
// accepted. A write with both stages full is dropped and flagged.
// Also tracks how many edges the latched byte has been present, saturating
// at HS_DELAY, so the handshake logic can time its data-valid strobe.
module dbo_latch_pair #(
    parameter int DW       = 8,
    parameter int HS_DELAY = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          accept,
    output logic [DW-1:0] port_data,
    output logic          olat_full,
    output logic          fbuf_full,
    output logic          wr_reject,
    output logic          settled
);
    localparam int AW = $clog2(HS_DELAY + 1);

    logic [DW-1:0] fbuf_q;
    logic [AW-1:0] age_q;
    logic [AW-1:0] age_inc;
    logic          wr_ok;

    assign wr_ok   = wr_en & ~(olat_full & fbuf_full);
    assign age_inc = settled ? age_q : age_q + AW'(1);
    assign settled = (age_q == AW'(HS_DELAY));

    // Advance occupancy, data and latch age per write/accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_data <= '0;
            fbuf_q    <= '0;
            olat_full <= 1'b0;
            fbuf_full <= 1'b0;
            wr_reject <= 1'b0;
            age_q     <= '0;
        end else begin
            wr_reject <= wr_en & olat_full & fbuf_full;
            if (!olat_full || accept) begin
                if (fbuf_full) begin
                    port_data <= fbuf_q;
                    olat_full <= 1'b1;
                    age_q     <= '0;
                    fbuf_full <= wr_ok;
                    if (wr_ok) fbuf_q <= wr_data;
                end else if (wr_en) begin
                    port_data <= wr_data;
                    olat_full <= 1'b1;
                    age_q     <= '0;
                end else begin
                    olat_full <= 1'b0;
                    age_q     <= age_inc;
                end
            end else begin
                if (wr_ok && !fbuf_full) begin
                    fbuf_q    <= wr_data;
                    fbuf_full <= 1'b1;
                end
                age_q <= age_inc;
            end
        end
    end

    // R2: front stage is only occupied behind a full latch.
    a_r2_front_behind_latch: assert property (@(posedge clk) disable iff (!rst_n)
        fbuf_full |-> olat_full);
    // R2: an unaccepted latched byte stays put.
    a_r2_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (olat_full && !accept) |=> (olat_full && $stable(port_data)));
    // R7: a freshly loaded byte is never reported settled.
    a_r7_fresh_not_settled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(olat_full) |-> !settled);
endmodule

// File: rtl/dbo_h2_ctrl.sv
// H2 pin behaviour, H2 status flag and acknowledge qualification.
// Assumes ack_rise/hs_rise come from a same-clock edge detector.
// In interlocked mode the negation on acknowledge is combinational.
module dbo_h2_ctrl
    import dbo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  h2_mode_e   mode,
    input  logic       enable,
    input  logic       ack_rise,
    input  logic       hs_rise,
    input  logic       h2s_clr,
    input  logic       olat_full,
    input  logic       settled,
    output logic       accept,
    output logic       hs_out,
    output logic       hs_drive,
    output logic       h2_status
);
    logic hs_lvl;

    assign hs_lvl   = (mode == H2_INTERLOCK) & enable & olat_full & settled;
    assign accept   = ack_rise & olat_full & ((mode != H2_INTERLOCK) | hs_lvl);
    assign hs_drive = (mode != H2_EDGE_IN);

    // Select the pin value for the current mode.
    always_comb begin
        unique case (mode)
            H2_EDGE_IN:   hs_out = 1'b0;
            H2_DRIVE_LO:  hs_out = 1'b0;
            H2_DRIVE_HI:  hs_out = 1'b1;
            H2_INTERLOCK: hs_out = hs_lvl & ~ack_rise;
            default:      hs_out = 1'b0;
        endcase
    end

    // Capture H2 input edges; clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          h2_status <= 1'b0;
        else if (mode != H2_EDGE_IN || !enable || h2s_clr)   h2_status <= 1'b0;
        else if (hs_rise)                                    h2_status <= 1'b1;
    end

    // R11: status flag reads zero outside edge-input mode.
    a_r11_status_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != H2_EDGE_IN) |=> !h2_status);
    // R8: the data-valid strobe only stands over a latched byte.
    a_r8_strobe_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == H2_INTERLOCK && hs_out) |-> olat_full);
    // R9: no acceptance while the strobe is low in interlocked mode.
    a_r9_no_accept_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == H2_INTERLOCK && !hs_lvl) |-> !accept);
    // R10: disabled interlock never drives the strobe.
    a_r10_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == H2_INTERLOCK && !enable) |-> !hs_out);
endmodule

// File: rtl/dbo_port.sv
// Double-buffered output handshake port (top level).
// Host writes feed a two-stage path to the peripheral; H1 acknowledges,
// H2 is mode-programmable. All inputs assumed synchronous to clk.
module dbo_port
    import dbo_pkg::*;
#(
    parameter int DW       = 8,
    parameter int HS_DELAY = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          wr_reject,
    input  logic          ack_in,
    input  logic          hs_in,
    output logic          hs_out,
    output logic          hs_drive,
    output logic [DW-1:0] port_data,
    input  logic          enable,
    input  logic [1:0]    h2_mode,
    input  logic          h1s_sel,
    input  logic          h2s_clr,
    output logic          h1_status,
    output logic          h2_status
);
    logic [1:0] rises;
    logic       accept, olat_full, fbuf_full, settled;
    h2_mode_e   mode;

    assign mode = h2_mode_e'(h2_mode);

    dbo_rise_det #(.W(2)) u_edges (
        .clk(clk), .rst_n(rst_n), .sig({hs_in, ack_in}), .rise(rises)
    );

    dbo_latch_pair #(.DW(DW), .HS_DELAY(HS_DELAY)) u_path (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .accept(accept), .port_data(port_data), .olat_full(olat_full),
        .fbuf_full(fbuf_full), .wr_reject(wr_reject), .settled(settled)
    );

    dbo_h2_ctrl u_h2 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .enable(enable),
        .ack_rise(rises[0]), .hs_rise(rises[1]), .h2s_clr(h2s_clr),
        .olat_full(olat_full), .settled(settled), .accept(accept),
        .hs_out(hs_out), .hs_drive(hs_drive), .h2_status(h2_status)
    );

    // Acknowledge status: room available, or fully drained.
    assign h1_status = h1s_sel ? ~(olat_full | fbuf_full) : ~(olat_full & fbuf_full);

    // R5: reject pulses last exactly one cycle without a new write.
    a_r5_reject_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_reject && !wr_en) |=> !wr_reject);
    // R4: drained status implies nothing on the output latch.
    a_r4_drained_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (h1s_sel && h1_status) |-> !olat_full);
endmodule

// File: tb/dbo_port_test.sv
module dbo_port_test;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_reject;
    logic          ack_in = 1'b0;
    logic          hs_in = 1'b0;
    logic          hs_out, hs_drive;
    logic [DW-1:0] port_data;
    logic          enable = 1'b1;
    logic [1:0]    h2_mode = 2'b01;
    logic          h1s_sel = 1'b0;
    logic          h2s_clr = 1'b0;
    logic          h1_status, h2_status;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dbo_port #(.DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_reject(wr_reject), .ack_in(ack_in), .hs_in(hs_in),
        .hs_out(hs_out), .hs_drive(hs_drive), .port_data(port_data),
        .enable(enable), .h2_mode(h2_mode), .h1s_sel(h1s_sel),
        .h2s_clr(h2s_clr), .h1_status(h1_status), .h2_status(h2_status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [DW-1:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic ack_pulse();
        @(negedge clk); ack_in = 1'b1;
        @(negedge clk); ack_in = 1'b0;
    endtask

    task automatic drained(input string req, input logic exp);
        h1s_sel = 1'b1; #1;
        chk(req, h1_status, exp);
        h1s_sel = 1'b0; #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 port_data", port_data, 0);
        chk("R1 hs_out", hs_out, 0);
        chk("R1 h2_status", h2_status, 0);
        chk("R1 wr_reject", wr_reject, 0);
        chk("R1 h1 room", h1_status, 1);
        drained("R1 h1 drained", 1'b1);
    endtask

    task automatic t_flow();
        h2_mode = 2'b01;
        wr(8'hA1);
        chk("R2 first byte", port_data, 8'hA1);
        chk("R3 room one used", h1_status, 1);
        drained("R4 not drained", 1'b0);
        wr(8'hB2);
        chk("R2 held", port_data, 8'hA1);
        chk("R3 no room", h1_status, 0);
        ack_pulse();
        chk("R2 front moves", port_data, 8'hB2);
        chk("R3 room again", h1_status, 1);
        @(negedge clk); ack_in = 1'b1;
        @(negedge clk);
        drained("R6 accepted B2", 1'b1);
        wr_en = 1'b1; wr_data = 8'hC3;
        @(negedge clk); wr_en = 1'b0;
        @(negedge clk);
        chk("R6 level held no accept", port_data, 8'hC3);
        drained("R6 level held still full", 1'b0);
        ack_in = 1'b0;
        ack_pulse();
        drained("R4 drained after ack", 1'b1);
        ack_pulse();
        wr(8'hD4);
        chk("R6 empty ack no effect", port_data, 8'hD4);
        drained("R6 byte kept", 1'b0);
        ack_pulse();
    endtask

    task automatic t_overflow();
        wr(8'h11);
        wr(8'h22);
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h33;
        @(negedge clk); wr_en = 1'b0;
        chk("R5 reject pulse", wr_reject, 1);
        chk("R5 latch unchanged", port_data, 8'h11);
        @(negedge clk);
        chk("R5 pulse one cycle", wr_reject, 0);
        ack_pulse();
        chk("R5 front unchanged", port_data, 8'h22);
        ack_pulse();
        drained("R5 dropped byte absent", 1'b1);
    endtask

    task automatic t_interlock();
        h2_mode = 2'b11; enable = 1'b1;
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h5A;
        @(negedge clk); wr_en = 1'b0;
        chk("R7 low after load", hs_out, 0);
        ack_in = 1'b1;
        @(negedge clk);
        chk("R7 low one edge", hs_out, 0);
        ack_in = 1'b0;
        @(negedge clk);
        chk("R7 high two edges", hs_out, 1);
        chk("R9 early ack ignored", port_data, 8'h5A);
        drained("R9 still full", 1'b0);
        wr_en = 1'b1; wr_data = 8'h6B;
        @(negedge clk); wr_en = 1'b0;
        chk("R8 high before ack", hs_out, 1);
        ack_in = 1'b1; #1;
        chk("R8 async negation", hs_out, 0);
        @(negedge clk); ack_in = 1'b0;
        chk("R8 next byte", port_data, 8'h6B);
        chk("R8 low after reload", hs_out, 0);
        @(negedge clk);
        chk("R8 low one edge", hs_out, 0);
        @(negedge clk);
        chk("R8 reasserted", hs_out, 1);
        ack_pulse();
        chk("R8 low when empty", hs_out, 0);
        drained("R8 drained", 1'b1);
    endtask

    task automatic t_enable();
        h2_mode = 2'b11; enable = 1'b0;
        wr(8'h77);
        repeat (3) @(negedge clk);
        chk("R10 held low", hs_out, 0);
        ack_pulse();
        chk("R10 ack ignored", port_data, 8'h77);
        drained("R10 still full", 1'b0);
        enable = 1'b1; #1;
        chk("R10 reenabled", hs_out, 1);
        ack_pulse();
        drained("R10 drained", 1'b1);
    endtask

    task automatic t_fixed();
        h2_mode = 2'b01; #1;
        chk("R11 R13 mode01 low", hs_out, 0);
        chk("R11 mode01 drive", hs_drive, 1);
        h2_mode = 2'b10; #1;
        chk("R11 R13 mode10 high", hs_out, 1);
        chk("R11 mode10 drive", hs_drive, 1);
        @(negedge clk); hs_in = 1'b1;
        @(negedge clk);
        @(negedge clk); hs_in = 1'b0;
        chk("R11 status zero", h2_status, 0);
        h2_mode = 2'b00; #1;
        chk("R13 mode00 input", hs_drive, 0);
        chk("R13 mode00 pin low", hs_out, 0);
    endtask

    task automatic t_edge_in();
        h2_mode = 2'b00; enable = 1'b1; hs_in = 1'b0;
        @(negedge clk); hs_in = 1'b1;
        @(negedge clk);
        chk("R12 edge sets", h2_status, 1);
        h2s_clr = 1'b1;
        @(negedge clk); h2s_clr = 1'b0;
        chk("R12 direct clear", h2_status, 0);
        @(negedge clk);
        chk("R12 level no retrigger", h2_status, 0);
        hs_in = 1'b0;
        @(negedge clk); hs_in = 1'b1;
        @(negedge clk);
        chk("R12 second edge", h2_status, 1);
        enable = 1'b0;
        @(negedge clk); enable = 1'b1;
        chk("R12 enable clears", h2_status, 0);
        hs_in = 1'b0;
        @(negedge clk); hs_in = 1'b1; h2s_clr = 1'b1;
        @(negedge clk); h2s_clr = 1'b0;
        chk("R12 clear wins", h2_status, 0);
        hs_in = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_flow();
        t_overflow();
        t_interlock();
        t_enable();
        t_fixed();
        t_edge_in();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule